// File: doc/BRIEF.md
# LCD Access Busy-Wait Timer

Each access by the processor to the display controller's command or data port opens a busy window. The block times that window and shows it both as an active-high busy flag and as the inverted ready bit of a polled status byte. The window length is picked from an eight-entry duration list whose entries run from 48 cycles upward in steps of 64. The index into that list is a bit field of a delay-configuration register, and which field is used depends on the current processor speed mode.

A small state machine holds the timer. Its states are IDLE (no window open) and WAIT (counting down). Its transitions are START (IDLE to WAIT on an access in modes 1 to 3), RELOAD (WAIT to WAIT on a further access, which restarts the count), EXPIRE (WAIT to IDLE when the count reaches zero) and HOLD (staying in the current state when nothing happens). In speed mode 0 an access does nothing: a window already running keeps counting, and an idle timer stays idle.

Top module: `lcd_busy_timer`

## Requirements
- R1: After reset the busy flag is 0 and status bit 1 reads 1.
- R2: The speed mode is bits 1:0 of the speed register. In mode 0 an access starts no window and leaves the busy flag and the countdown as they were.
- R3: In mode 1 the duration index is delay-config bits 1:0 (zero-extended). In mode 2 it is bits 4:2. In mode 3 it is bits 7:5.
- R4: The duration for index i is 48 + 64*i cycles. After an access strobe sampled at edge E, busy is 1 from edge E through edge E+D-1 and is 0 after edge E+D.
- R5: An access in modes 1 to 3 during an open window reloads the count with the duration now selected, measured from that access.
- R6: Status bit 1 is the inverse of the busy flag. The other status bits read 0.
- R7: The countdown never wraps. When the state is IDLE, busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_reg | input | 8 | Speed-mode register; only bits 1:0 are used |
| dly_cfg | input | 8 | Delay-configuration register holding the three index fields |
| lcd_access | input | 1 | One-cycle strobe for any read or write of the display command or data port |
| busy | output | 1 | High while a busy window is open |
| status | output | 8 | Status byte; bit 1 is the ready bit (inverse of busy) |

## Verification
The hardest situation to reach is a reload late in an open window that switches to a shorter duration, together with a mode-0 access arriving mid-window. An access in mode 0 must leave the running count untouched. The bench reaches both by issuing a long window, waiting a computed number of edges, changing the speed and configuration registers and strobing again. It then measures the exact edge at which busy falls. Every mode and every index is swept, and each window length is measured edge by edge against 48+64*i.

// File: rtl/lcd_busy_pkg.sv
package lcd_busy_pkg;
    localparam int IDX_W   = 3;
    localparam int CNT_W   = 9;
    localparam int BASE_D  = 48;
    localparam int STEP_D  = 64;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } wait_state_t;

    typedef enum logic [1:0] {
        SPD_SLOW = 2'd0,
        SPD_M1   = 2'd1,
        SPD_M2   = 2'd2,
        SPD_M3   = 2'd3
    } speed_t;
endpackage

// File: rtl/lcd_busy_index_sel.sv
module lcd_busy_index_sel
    import lcd_busy_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic [1:0]       mode,
    input  logic [CFG_W-1:0] cfg,
    output logic [IDX_W-1:0] idx,
    output logic             enable
);
    always_comb begin
        idx    = '0;
        enable = 1'b1;
        unique case (speed_t'(mode))
            SPD_SLOW: enable = 1'b0;
            SPD_M1:   idx = {1'b0, cfg[1:0]};
            SPD_M2:   idx = cfg[4:2];
            SPD_M3:   idx = cfg[7:5];
        endcase
    end

    // R3: a disabled selector reports index zero
    always_comb begin
        if (!enable) a_slow_idx_r3: assert (idx == '0);
    end
endmodule

// File: rtl/lcd_busy_duration.sv
module lcd_busy_duration
    import lcd_busy_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] dur
);
    localparam logic [CNT_W-1:0] BASE = CNT_W'(BASE_D);
    always_comb dur = BASE + ({{(CNT_W-IDX_W){1'b0}}, idx} << 6);

    // R4: durations stay within the legal window
    always_comb begin
        a_dur_range_r4: assert (dur >= CNT_W'(BASE_D) && dur <= CNT_W'(BASE_D + 7*STEP_D));
    end
endmodule

// File: rtl/lcd_busy_fsm.sv
module lcd_busy_fsm
    import lcd_busy_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] dur,
    output logic             busy
);
    wait_state_t st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d  = ST_WAIT;
                    cnt_d = dur - 1'b1;
                end
            end
            ST_WAIT: begin
                if (start) begin
                    cnt_d = dur - 1'b1;
                end else if (cnt_q == '0) begin
                    st_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: busy = 1'b0;
            ST_WAIT: busy = 1'b1;
        endcase
    end

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && !start && cnt_q == '0) |=> (st_q == ST_IDLE));
    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && !start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !start) |=> (st_q == ST_IDLE));
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && cnt_q == $past(dur) - 1'b1));
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer
    import lcd_busy_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] speed_reg,
    input  logic [7:0] dly_cfg,
    input  logic       lcd_access,
    output logic       busy,
    output logic [7:0] status
);
    logic [IDX_W-1:0] idx;
    logic             en;
    logic [CNT_W-1:0] dur;

    lcd_busy_index_sel #(.CFG_W(8)) sel_i (
        .mode(speed_reg[1:0]), .cfg(dly_cfg), .idx(idx), .enable(en));
    lcd_busy_duration dur_i (.idx(idx), .dur(dur));
    lcd_busy_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .start(lcd_access && en), .dur(dur), .busy(busy));

    always_comb status = {6'b0, ~busy, 1'b0};

    p_slow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_access && speed_reg[1:0] == 2'd0 && !busy) |=> !busy);
    p_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] != busy);
endmodule

// File: tb/lcd_busy_timer_tb_top.sv
module lcd_busy_timer_tb_top;
    logic clk = 0, rst_n = 0, acc = 0;
    logic [7:0] spd = 0, cfg = 0;
    logic busy;
    logic [7:0] status;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    lcd_busy_timer dut_i (.clk(clk), .rst_n(rst_n), .speed_reg(spd), .dly_cfg(cfg),
        .lcd_access(acc), .busy(busy), .status(status));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // strobe across one edge; returns after that edge at negedge
    task automatic strobe();
        acc = 1;
        @(posedge clk); #1 acc = 0;
        @(negedge clk);
    endtask

    // count edges until busy falls; returns the window length
    task automatic measure(output int len);
        len = 1;
        while (busy && len < 2000) begin
            @(posedge clk); @(negedge clk);
            len++;
        end
        len--;
    endtask

    function automatic int expd(int mode, logic [7:0] c);
        int i;
        case (mode)
            1: i = c[1:0];
            2: i = c[4:2];
            default: i = c[7:5];
        endcase
        return 48 + 64 * i;
    endfunction

    initial begin
        int len;
        #2000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int len, e;
        @(negedge clk); @(negedge clk);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(status == 8'h02, "R1 status", status, 2);
        rst_n = 1;
        @(negedge clk);
        // R3/R4 sweep all modes and indices
        for (int m = 1; m < 4; m++) begin
            for (int i = 0; i < 8; i++) begin
                if (m == 1 && i > 3) continue;
                spd = 8'hF0 | 8'(m);
                case (m)
                    1: cfg = 8'hFC | 8'(i);
                    2: cfg = 8'hE3 | 8'(i << 2);
                    default: cfg = 8'h1F | 8'(i << 5);
                endcase
                strobe();
                chk(busy == 1, "R4 busy rise", busy, 1);
                chk(status == 8'h00, "R6 status busy", status, 0);
                measure(len);
                e = expd(m, cfg);
                chk(len == e, "R3 R4 window length", len, e);
                chk(status == 8'h02, "R6 status ready", status, 2);
                repeat (3) @(negedge clk);
                chk(busy == 0, "R7 stays idle", busy, 0);
            end
        end
        // R2 mode 0 from idle
        spd = 8'h00; cfg = 8'hFF;
        strobe();
        chk(busy == 0, "R2 slow idle", busy, 0);
        // R2 mode 0 mid-window: count unaffected
        spd = 8'h03; cfg = 8'h00; // 48
        strobe();
        repeat (9) @(negedge clk);
        spd = 8'h00; cfg = 8'hFF;
        strobe();
        measure(len);
        chk(len == 48 - 10, "R2 slow mid-window", len, 38);
        // R5 reload to shorter duration
        spd = 8'h02; cfg = 8'h1C; // 496
        strobe();
        repeat (299) @(negedge clk);
        spd = 8'h01; cfg = 8'h00; // 48
        strobe();
        measure(len);
        chk(len == 48, "R5 reload shorter", len, 48);
        // R5 reload to longer
        spd = 8'h01; cfg = 8'h00;
        strobe();
        repeat (19) @(negedge clk);
        spd = 8'h03; cfg = 8'h20; // 112
        strobe();
        measure(len);
        chk(len == 112, "R5 reload longer", len, 112);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule